// File: doc/BRIEF.md
# Quadrature-Capable Timer Channel

This block is a single 16-bit timer channel for an on-chip peripheral subsystem. A counter advances on a clock-enable strobe. Two pins, A and B, each act either as a compare output (the pin toggles when the counter equals its register) or as a capture input (a rising edge copies the counter into its register). Matches and captures raise sticky interrupt flags. A match or capture on channel A also produces a one-cycle DMA request.

A mode field selects one of three behaviours. Normal mode is free-running counting, with an optional clear on an A match. PWM mode drives pin A high on an A match and low on a B match, and the counter restarts at each A match. Phase-counting mode counts up or down on each edge of two quadrature inputs taken from the pins. Two external strobes, sync start and sync clear, let several channels start and clear together. The clear-on-match event is also sent out, so one channel can lead the others.

A four-state machine follows the run bit and the mode field. The states are STOP, FREE (normal counting), PWM and QUAD (phase counting). The transitions are: STOP goes to the state for the current mode once the run bit is set. Any running state goes to STOP when the run bit is cleared. Any running state goes to the state of a newly written mode while the run bit stays set. Mode code 3 is treated as normal.

Top module: `quad_timer_chan`

## Requirements
- R1: After reset the counter and CTRL are 0, both data registers are 0xFFFF, and both flags, dma_req, sync_clear_out and both pin outputs are 0. Both output enables are 1, because reset leaves the pins in compare use.
- R2: The register addresses are CTRL=0, STAT=1, COUNT=2, REGA=3 and REGB=4. The CTRL bits are: bit0 run, bits2:1 mode (0 normal, 1 PWM, 2 phase, 3 normal), bit3 pin A capture, bit4 pin B capture, bit5 clear on A match, bit6 sync enable. rdata is 0 while rd_en is low. A bus write to COUNT takes priority over counting.
- R3: In STOP the counter holds its value. In FREE it adds 1 on each cycle where tick_en is high, and it wraps from 0xFFFF to 0.
- R4: In normal mode a compare pin whose register equals the counter on a tick sets its flag and toggles its output. A compare pin drives its output enable high.
- R5: When clear-on-A is set in normal mode, an A match loads the counter with 0 instead of adding 1, and sync_clear_out pulses for one cycle.
- R6: A pin in capture use (normal mode, running or stopped) is passed through a two-flop synchronizer. On a rising edge it copies the counter into its register and sets its flag, and its output enable is low. Falling edges, and edges on a pin in compare use, leave the register unchanged.
- R7: STAT bit0 (A) and bit1 (B) are sticky flags that drive irq_a and irq_b. Writing 1 to a STAT bit clears it, writing 0 has no effect, and a new event in the same cycle wins over the clear.
- R8: dma_req is a one-cycle pulse for each A match or A capture. It stays low for B events.
- R9: In PWM mode pin A goes high after an A match and low after a B match, and the counter restarts at 0 after an A match. With REGA=N and REGB=M<N, the period is N+1 ticks and the pin is high for M+1 of them. Pin B's output enable is low and pin A's is high.
- R10: In phase mode the synchronized pins are phase inputs and both output enables are low. An edge on A counts up if the new A differs from B. An edge on B counts up if the new B equals A. Otherwise an edge counts down, so A leading B counts up. The counter wraps in both directions.
- R11: When the sync-enable bit is set, a sync_start_in pulse sets the run bit and a sync_clear_in pulse loads the counter with 0. When the bit is clear, both strobes are ignored.
- R12: The state machine moves between STOP, FREE, PWM and QUAD as described above, one cycle after the run bit or mode field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable for FREE and PWM |
| sync_start_in | input | 1 | Shared start strobe |
| sync_clear_in | input | 1 | Shared clear strobe |
| sync_clear_out | output | 1 | Pulse when an A match clears the counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational |
| pin_a_in | input | 1 | Pin A input level |
| pin_b_in | input | 1 | Pin B input level |
| pin_a_out | output | 1 | Pin A drive value |
| pin_b_out | output | 1 | Pin B drive value |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_oe | output | 1 | Pin B output enable |
| irq_a | output | 1 | Channel A flag |
| irq_b | output | 1 | Channel B flag |
| dma_req | output | 1 | Channel A DMA request pulse |

## Verification
Counting is tried across the 0xFFFF wrap with the run bit both set and cleared, which separates a working enable from a counter that always runs. The phase inputs receive two full forward quadrature cycles and then reversed steps, including a step down through zero. This tells direction decoding apart from plain edge counting. PWM is measured as the high-cycle count over a whole number of periods, which exposes off-by-one errors in the match and restart logic. Captures are tried on rising and falling edges, on a pin in compare use, and on pin B. These separate true edge capture from level sampling and from cross-channel DMA leakage.

// File: rtl/qtc_pkg.sv
package qtc_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_FREE = 2'd1,
        ST_PWM  = 2'd2,
        ST_QUAD = 2'd3
    } qtc_state_e;

    localparam logic [1:0] MODE_NORM = 2'd0;
    localparam logic [1:0] MODE_PWM  = 2'd1;
    localparam logic [1:0] MODE_QUAD = 2'd2;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_STAT  = 3'd1;
    localparam logic [2:0] ADR_COUNT = 3'd2;
    localparam logic [2:0] ADR_REGA  = 3'd3;
    localparam logic [2:0] ADR_REGB  = 3'd4;

    localparam int CB_RUN  = 0;
    localparam int CB_MODE = 1;
    localparam int CB_CAPA = 3;
    localparam int CB_CAPB = 4;
    localparam int CB_CLRA = 5;
    localparam int CB_SYNC = 6;
    localparam int CTRL_W  = 7;

endpackage

// File: rtl/qtc_sync.sv
module qtc_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;
endmodule

// File: rtl/qtc_quad.sv
module qtc_quad (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    output logic step_up,
    output logic step_dn
);
    logic pa_q;
    logic pb_q;
    logic a_edge;
    logic b_edge;
    logic a_only;
    logic b_only;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q <= 1'b0;
            pb_q <= 1'b0;
        end else begin
            pa_q <= ph_a;
            pb_q <= ph_b;
        end
    end

    assign a_edge  = ph_a ^ pa_q;
    assign b_edge  = ph_b ^ pb_q;
    assign a_only  = a_edge & ~b_edge;
    assign b_only  = b_edge & ~a_edge;
    assign step_up = (a_only & (ph_a != ph_b)) | (b_only & (ph_b == ph_a));
    assign step_dn = (a_only & (ph_a == ph_b)) | (b_only & (ph_b != ph_a));
endmodule

// File: rtl/qtc_pin.sv
module qtc_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic cap_ok,
    input  logic set_hi,
    input  logic set_lo,
    input  logic toggle,
    output logic cap_evt,
    output logic pin_out
);
    logic prev_q;
    logic drv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            drv_q  <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (set_hi)
                drv_q <= 1'b1;
            else if (set_lo)
                drv_q <= 1'b0;
            else if (toggle)
                drv_q <= ~drv_q;
        end
    end

    assign cap_evt = cap_ok & pin_s & ~prev_q;
    assign pin_out = drv_q;
endmodule

// File: rtl/quad_timer_chan.sv
module quad_timer_chan
    import qtc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          sync_start_in,
    input  logic          sync_clear_in,
    output logic          sync_clear_out,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    input  logic          pin_a_in,
    input  logic          pin_b_in,
    output logic          pin_a_out,
    output logic          pin_b_out,
    output logic          pin_a_oe,
    output logic          pin_b_oe,
    output logic          irq_a,
    output logic          irq_b,
    output logic          dma_req
);
    localparam int NPIN = 2;
    localparam logic [CW-1:0] ONES = {CW{1'b1}};

    qtc_state_e state_q, state_d, target;

    logic [CW-1:0] count_q, count_d;
    logic [CW-1:0] reg_a_q, reg_b_q;
    logic          run_q, cap_a_q, cap_b_q, clr_a_q, sync_en_q;
    logic [1:0]    mode_q;
    logic [NPIN-1:0] flag_q;
    logic          dma_q, sclr_q;

    logic wr_ctrl, wr_stat, wr_cnt, wr_a, wr_b;
    logic ticking, pwm_on, hit_a, hit_b, clear_a, sync_clr;
    logic step_up, step_dn;
    logic [NPIN-1:0] pin_s, cap_cfg, cap_ok, set_hi, set_lo, tgl, cap_evt, drv;
    logic [CW-1:0] ctrl_rd;

    // ---------------- bus decode ----------------
    assign wr_ctrl = wr_en && addr == ADR_CTRL;
    assign wr_stat = wr_en && addr == ADR_STAT;
    assign wr_cnt  = wr_en && addr == ADR_COUNT;
    assign wr_a    = wr_en && addr == ADR_REGA;
    assign wr_b    = wr_en && addr == ADR_REGB;

    // ---------------- pin front end ----------------
    qtc_sync #(.WIDTH(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({pin_b_in, pin_a_in}),
        .synced (pin_s)
    );

    qtc_quad u_quad (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph_a    (pin_s[0]),
        .ph_b    (pin_s[1]),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    assign pwm_on  = state_q == ST_PWM;
    assign ticking = tick_en && (state_q == ST_FREE || state_q == ST_PWM);
    assign hit_a   = ticking && (pwm_on || !cap_a_q) && count_q == reg_a_q;
    assign hit_b   = ticking && (pwm_on || !cap_b_q) && count_q == reg_b_q;
    assign clear_a = hit_a && (pwm_on || clr_a_q);
    assign sync_clr = sync_en_q && sync_clear_in;

    assign cap_cfg = {cap_b_q, cap_a_q};
    assign set_hi  = {1'b0, pwm_on && hit_a};
    assign set_lo  = {1'b0, pwm_on && hit_b};
    assign tgl     = {!pwm_on && hit_b, !pwm_on && hit_a};

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            assign cap_ok[i] = cap_cfg[i] && (state_q == ST_STOP || state_q == ST_FREE);
            qtc_pin u_pin (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_s   (pin_s[i]),
                .cap_ok  (cap_ok[i]),
                .set_hi  (set_hi[i]),
                .set_lo  (set_lo[i]),
                .toggle  (tgl[i]),
                .cap_evt (cap_evt[i]),
                .pin_out (drv[i])
            );
        end
    endgenerate

    // ---------------- state machine ----------------
    always_comb begin
        unique case (mode_q)
            MODE_PWM:  target = ST_PWM;
            MODE_QUAD: target = ST_QUAD;
            default:   target = ST_FREE;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run_q) state_d = target;
            ST_FREE, ST_PWM, ST_QUAD: begin
                if (!run_q) state_d = ST_STOP;
                else        state_d = target;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // ---------------- counter next value ----------------
    always_comb begin
        count_d = count_q;
        unique case (state_q)
            ST_STOP: count_d = count_q;
            ST_FREE, ST_PWM: begin
                if (tick_en) count_d = clear_a ? '0 : count_q + 1'b1;
            end
            ST_QUAD: begin
                if (step_up)      count_d = count_q + 1'b1;
                else if (step_dn) count_d = count_q - 1'b1;
            end
        endcase
        if (sync_clr) count_d = '0;
        if (wr_cnt)   count_d = wdata;
    end

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            reg_a_q   <= ONES;
            reg_b_q   <= ONES;
            run_q     <= 1'b0;
            mode_q    <= MODE_NORM;
            cap_a_q   <= 1'b0;
            cap_b_q   <= 1'b0;
            clr_a_q   <= 1'b0;
            sync_en_q <= 1'b0;
            flag_q    <= '0;
            dma_q     <= 1'b0;
            sclr_q    <= 1'b0;
        end else begin
            count_q <= count_d;
            if (wr_a)            reg_a_q <= wdata;
            else if (cap_evt[0]) reg_a_q <= count_q;
            if (wr_b)            reg_b_q <= wdata;
            else if (cap_evt[1]) reg_b_q <= count_q;
            if (wr_ctrl) begin
                run_q     <= wdata[CB_RUN];
                mode_q    <= wdata[CB_MODE +: 2];
                cap_a_q   <= wdata[CB_CAPA];
                cap_b_q   <= wdata[CB_CAPB];
                clr_a_q   <= wdata[CB_CLRA];
                sync_en_q <= wdata[CB_SYNC];
            end else if (sync_en_q && sync_start_in) begin
                run_q <= 1'b1;
            end
            flag_q[0] <= hit_a || cap_evt[0] || (flag_q[0] && !(wr_stat && wdata[0]));
            flag_q[1] <= hit_b || cap_evt[1] || (flag_q[1] && !(wr_stat && wdata[1]));
            dma_q  <= hit_a || cap_evt[0];
            sclr_q <= clear_a;
        end
    end

    // ---------------- outputs ----------------
    assign ctrl_rd = CW'({sync_en_q, clr_a_q, cap_b_q, cap_a_q, mode_q, run_q});

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADR_CTRL:  rdata = ctrl_rd;
                ADR_STAT:  rdata = CW'(flag_q);
                ADR_COUNT: rdata = count_q;
                ADR_REGA:  rdata = reg_a_q;
                ADR_REGB:  rdata = reg_b_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign pin_a_out      = drv[0];
    assign pin_b_out      = drv[1];
    assign pin_a_oe       = mode_q != MODE_QUAD && (mode_q == MODE_PWM || !cap_a_q);
    assign pin_b_oe       = mode_q != MODE_QUAD && mode_q != MODE_PWM && !cap_b_q;
    assign irq_a          = flag_q[0];
    assign irq_b          = flag_q[1];
    assign dma_req        = dma_q;
    assign sync_clear_out = sclr_q;
endmodule

// File: rtl/qtc_chk.sv
module qtc_chk
    import qtc_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input qtc_state_e    state,
    input logic [1:0]    mode,
    input logic          cap_a,
    input logic          sync_en,
    input logic [CW-1:0] count,
    input logic [CW-1:0] reg_a,
    input logic          tick_en,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic [CW-1:0] wdata,
    input logic          sync_clear_in,
    input logic          irq_a,
    input logic          dma_req,
    input logic          pin_a_oe,
    input logic          pin_b_oe
);
    logic quiet;
    assign quiet = !wr_en && !(sync_en && sync_clear_in);

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && quiet) |=> $stable(count)); // R3

    AST_PWM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWM && tick_en && count == reg_a && quiet) |=> count == '0); // R9

    AST_QUAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUAD && quiet) |=>
            (count == $past(count) || count == $past(count) + 1'b1 || count == $past(count) - 1'b1)); // R10

    AST_QUAD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_QUAD) |-> (!pin_a_oe && !pin_b_oe)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a && !(wr_en && addr == ADR_STAT && wdata[0])) |=> irq_a); // R7

    AST_DMA_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> irq_a); // R8

    AST_CAPTURE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORM && cap_a) |-> !pin_a_oe); // R6
endmodule

bind quad_timer_chan qtc_chk #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .mode          (mode_q),
    .cap_a         (cap_a_q),
    .sync_en       (sync_en_q),
    .count         (count_q),
    .reg_a         (reg_a_q),
    .tick_en       (tick_en),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .sync_clear_in (sync_clear_in),
    .irq_a         (irq_a),
    .dma_req       (dma_req),
    .pin_a_oe      (pin_a_oe),
    .pin_b_oe      (pin_b_oe)
);

// File: tb/quad_timer_chan_bench.sv
`timescale 1ns/1ps
module quad_timer_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, sync_start_in = 1'b0, sync_clear_in = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        pin_a_in = 1'b0, pin_b_in = 1'b0;
    logic [15:0] rdata;
    logic        sync_clear_out, pin_a_out, pin_b_out, pin_a_oe, pin_b_oe, irq_a, irq_b, dma_req;

    int checks = 0, fails = 0, dma_cnt = 0, sclr_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    quad_timer_chan u_quad_timer_chan (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .sync_start_in(sync_start_in), .sync_clear_in(sync_clear_in),
        .sync_clear_out(sync_clear_out), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
        .pin_a_out(pin_a_out), .pin_b_out(pin_b_out),
        .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe),
        .irq_a(irq_a), .irq_b(irq_b), .dma_req(dma_req)
    );

    always @(negedge clk) begin
        if (dma_req) dma_cnt++;
        if (sync_clear_out) sclr_cnt++;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl(input bit run, input logic [1:0] mode,
                                         input bit capa, input bit capb,
                                         input bit clra, input bit sen);
        return {9'd0, sen, clra, capb, capa, mode, run};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd0, v); check("R1 ctrl", v, 16'h0000);
        rd(3'd2, v); check("R1 count", v, 16'h0000);
        rd(3'd3, v); check("R1 rega", v, 16'hFFFF);
        rd(3'd4, v); check("R1 regb", v, 16'hFFFF);
        check("R1 outs", {irq_a, irq_b, dma_req, sync_clear_out, pin_a_out, pin_b_out}, 16'h0);
        check("R1 oe", {pin_a_oe, pin_b_oe}, 16'h3);
        #1 check("R2 rdata idle", rdata, 16'h0000);
    endtask

    task automatic t_count;
        logic [15:0] v;
        wr(3'd3, 16'h8000); wr(3'd4, 16'h8000);
        wr(3'd2, 16'hFFFD);
        wr(3'd0, ctrl(1, 2'd0, 0, 0, 0, 0));
        idle(3);
        ticks(5);
        rd(3'd2, v); check("R3 wrap count", v, 16'h0002);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 0));
        idle(3);
        ticks(5);
        rd(3'd2, v); check("R12 stop holds", v, 16'h0002);
        wr(3'd2, 16'h0040);
        rd(3'd2, v); check("R2 count write", v, 16'h0040);
    endtask

    task automatic t_compare;
        logic [15:0] v;
        wr(3'd2, 16'h0000); wr(3'd3, 16'd10); wr(3'd4, 16'h0020);
        wr(3'd1, 16'h0003);
        wr(3'd0, ctrl(1, 2'd0, 0, 0, 0, 0));
        idle(3);
        dma_cnt = 0;
        ticks(12);
        rd(3'd2, v); check("R4 count after ticks", v, 16'd12);
        check("R4 irq_a/irq_b", {irq_a, irq_b}, 16'h2);
        check("R4 pin_a toggled", pin_a_out, 1'b1);
        check("R4 pin oe", {pin_a_oe, pin_b_oe}, 16'h3);
        idle(1);
        check("R8 one dma pulse", dma_cnt, 16'd1);
        idle(5);
        check("R7 sticky", irq_a, 1'b1);
        wr(3'd1, 16'h0002);
        check("R7 w1c other bit", irq_a, 1'b1);
        wr(3'd1, 16'h0001);
        check("R7 w1c clears", irq_a, 1'b0);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 0));
    endtask

    task automatic t_clear_a;
        logic [15:0] v;
        wr(3'd3, 16'd5); wr(3'd2, 16'd0);
        wr(3'd0, ctrl(1, 2'd0, 0, 0, 1, 0));
        idle(3);
        dma_cnt = 0; sclr_cnt = 0;
        ticks(40);
        idle(1);
        rd(3'd2, v); check("R5 count mod 6", v, 16'd4);
        check("R5 sync_clear_out pulses", sclr_cnt, 16'd6);
        check("R8 dma per match", dma_cnt, 16'd6);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 0));
        wr(3'd1, 16'h0003);
    endtask

    task automatic t_capture;
        logic [15:0] v;
        wr(3'd0, ctrl(0, 2'd0, 1, 1, 0, 0));
        check("R6 oe released", {pin_a_oe, pin_b_oe}, 16'h0);
        wr(3'd2, 16'h1234);
        dma_cnt = 0;
        @(negedge clk) pin_a_in = 1'b1;
        idle(5);
        rd(3'd3, v); check("R6 capture A", v, 16'h1234);
        check("R6 flag A", irq_a, 1'b1);
        check("R8 capture dma", dma_cnt, 16'd1);
        wr(3'd2, 16'h2222);
        @(negedge clk) pin_a_in = 1'b0;
        idle(5);
        rd(3'd3, v); check("R6 falling ignored", v, 16'h1234);
        wr(3'd1, 16'h0003);
        dma_cnt = 0;
        wr(3'd2, 16'h0BEE);
        @(negedge clk) pin_b_in = 1'b1;
        idle(5);
        rd(3'd4, v); check("R6 capture B", v, 16'h0BEE);
        check("R7 flag B only", {irq_a, irq_b}, 16'h1);
        check("R8 no dma for B", dma_cnt, 16'd0);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 0));
        wr(3'd3, 16'h0077);
        @(negedge clk) begin pin_a_in = 1'b1; pin_b_in = 1'b0; end
        idle(5);
        rd(3'd3, v); check("R6 compare pin ignores edge", v, 16'h0077);
        @(negedge clk) pin_a_in = 1'b0;
        idle(4);
        wr(3'd1, 16'h0003);
    endtask

    task automatic t_pwm;
        int high;
        high = 0;
        wr(3'd3, 16'd9); wr(3'd4, 16'd3); wr(3'd2, 16'd0);
        wr(3'd0, ctrl(1, 2'd1, 0, 0, 0, 0));
        @(negedge clk) tick_en = 1'b1;
        idle(30);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (pin_a_out) high++;
        end
        tick_en = 1'b0;
        check("R9 duty 4 of 10", high, 16'd40);
        check("R9 oe a=1 b=0", {pin_a_oe, pin_b_oe}, 16'h2);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 0));
    endtask

    task automatic step(input logic a, input logic b);
        @(negedge clk);
        pin_a_in = a; pin_b_in = b;
        idle(6);
    endtask

    task automatic t_phase;
        logic [15:0] v;
        pin_a_in = 1'b0; pin_b_in = 1'b0;
        idle(5);
        wr(3'd0, ctrl(1, 2'd2, 0, 0, 0, 0));
        idle(3);
        wr(3'd2, 16'd0);
        check("R10 oe off", {pin_a_oe, pin_b_oe}, 16'h0);
        for (int k = 0; k < 2; k++) begin
            step(1, 0); step(1, 1); step(0, 1); step(0, 0);
        end
        rd(3'd2, v); check("R10 forward 8", v, 16'd8);
        step(0, 1); step(1, 1); step(1, 0);
        rd(3'd2, v); check("R10 reverse 3", v, 16'd5);
        step(0, 0);
        wr(3'd2, 16'd0);
        step(0, 1);
        rd(3'd2, v); check("R10 wrap down", v, 16'hFFFF);
        step(0, 0);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 0));
    endtask

    task automatic t_sync;
        logic [15:0] v;
        wr(3'd3, 16'h8000);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 1));
        wr(3'd2, 16'h0100);
        @(negedge clk) sync_start_in = 1'b1;
        @(negedge clk) sync_start_in = 1'b0;
        rd(3'd0, v); check("R11 start sets run", v, 16'h0041);
        idle(2);
        ticks(3);
        rd(3'd2, v); check("R11 counting after start", v, 16'h0103);
        @(negedge clk) sync_clear_in = 1'b1;
        @(negedge clk) sync_clear_in = 1'b0;
        rd(3'd2, v); check("R11 sync clear", v, 16'h0000);
        wr(3'd0, ctrl(1, 2'd0, 0, 0, 0, 0));
        wr(3'd2, 16'h0055);
        @(negedge clk) sync_clear_in = 1'b1;
        @(negedge clk) sync_clear_in = 1'b0;
        rd(3'd2, v); check("R11 clear ignored", v, 16'h0055);
        wr(3'd0, ctrl(0, 2'd0, 0, 0, 0, 0));
        @(negedge clk) sync_start_in = 1'b1;
        @(negedge clk) sync_start_in = 1'b0;
        rd(3'd0, v); check("R11 start ignored", v, 16'h0000);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_count();
        t_compare();
        t_clear_a();
        t_capture();
        t_pwm();
        t_phase();
        t_sync();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end
endmodule